// File: doc/BRIEF.md
# Exception Address Capture Register

This block keeps the program address of the instruction group that raised an imprecise internal exception, so that the service routine can find out which group was at fault. Each cycle it sees the address of the group that is retiring, a strobe that marks that address as valid, a vector of illegal-class event pulses (one bit per sub-reason) and a single arithmetic-overflow event pulse. An acknowledge pulse from the service routine re-arms the capture.

The block tracks which exception class it currently holds. Within a class, only the first event is kept. An event of the other class always replaces the stored address, whether or not the held class was ever serviced. The register therefore holds the first occurrence of the most recent class. A small state machine records the held class. Its states are HOLD_NONE (armed for both classes), HOLD_ILL (illegal class held) and HOLD_OVF (overflow class held). Its transitions are:

- NONE→ILL and OVF→ILL on an illegal event.
- NONE→OVF and ILL→OVF on an overflow event.
- Any state→OVF when both classes fire in the same cycle.
- Any state→NONE on acknowledge when no event arrives.

The stored value is read-only. The same value is driven on a debug scan read port and on a core read port.

Top module: `exc_addr_capture`

## Requirements
- R1: After reset both read ports show 0, and the block holds no class, so the first qualified event of either class is captured.
- R2: A qualified event is one whose pulse is high in a cycle where `grp_valid` is high. When no class is held, a qualified event loads `grp_addr` into the register, visible on the ports one clock after that edge.
- R3: While a class is held, further qualified events of the same class leave the value unchanged. All bits of `ill_evt` (bit 0, bit 1 and bit 2 by default) belong to the single illegal class.
- R4: A qualified event of the class not currently held loads `grp_addr`, whether or not the held class was acknowledged. This applies from illegal to overflow and from overflow to illegal.
- R5: When both classes have a qualified event in the same cycle, that cycle's `grp_addr` is loaded and the overflow class becomes the held class. A later overflow event is then ignored and a later illegal event is captured.
- R6: `exc_ack` returns the block to holding no class. The stored address is kept until the next qualified event, which is then captured whatever its class. An event in the same cycle as `exc_ack` is treated as arriving after the acknowledge.
- R7: Event pulses in a cycle where `grp_valid` is low have no effect on the value or on the held class.
- R8: `dbg_rd_data` and `core_rd_data` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_addr | input | ADDR_W (32) | Address of the group retiring this cycle |
| grp_valid | input | 1 | Qualifies `grp_addr` and the event pulses |
| ill_evt | input | N_ILL (3) | Illegal-class event pulses, one per sub-reason |
| ovf_evt | input | 1 | Arithmetic-overflow event pulse |
| exc_ack | input | 1 | Acknowledge from the service routine; re-arms capture |
| dbg_rd_data | output | ADDR_W (32) | Captured address for the debug scan read |
| core_rd_data | output | ADDR_W (32) | Captured address for the core read |

## Verification
The properties assume the inputs are settled and free of X at every rising edge after reset. They also assume that a pulse on `ill_evt` or `ovf_evt` matters only when `grp_valid` qualifies it, so an unqualified pulse is legal input, not a protocol error. The stimulus changes every input on the falling edge only, keeps each signal at a defined 0 or 1 throughout, and deliberately mixes unqualified pulses, simultaneous classes and acknowledges that coincide with events. This exercises those freedoms without leaving them.

// File: rtl/exc_cap_pkg.sv
package exc_cap_pkg;

    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_ILL  = 2'd1,
        HOLD_OVF  = 2'd2
    } hold_e;

endpackage

// File: rtl/exc_cap_classify.sv
module exc_cap_classify #(
    parameter int N_ILL = 3
) (
    input  logic             grp_valid,
    input  logic [N_ILL-1:0] ill_evt,
    input  logic             ovf_evt,
    output logic             ill_hit,
    output logic             ovf_hit
);

    logic any_ill;

    generate
        if (N_ILL == 1) begin : g_single
            assign any_ill = ill_evt[0];
        end else begin : g_multi
            assign any_ill = |ill_evt;
        end
    endgenerate

    assign ill_hit = grp_valid & any_ill;
    assign ovf_hit = grp_valid & ovf_evt;

endmodule

// File: rtl/exc_cap_fsm.sv
module exc_cap_fsm
    import exc_cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ill_hit,
    input  logic  ovf_hit,
    input  logic  ack,
    output hold_e state,
    output logic  load
);

    hold_e base_st;
    hold_e next_st;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HOLD_NONE;
        end else begin
            state <= next_st;
        end
    end

    // next state and load strobe; acknowledge applies before same-cycle events
    always_comb begin
        base_st = ack ? HOLD_NONE : state;
        next_st = base_st;
        load    = 1'b0;
        unique case (base_st)
            HOLD_NONE: begin
                if (ovf_hit) begin
                    next_st = HOLD_OVF;
                    load    = 1'b1;
                end else if (ill_hit) begin
                    next_st = HOLD_ILL;
                    load    = 1'b1;
                end
            end
            HOLD_ILL: begin
                if (ovf_hit) begin
                    next_st = HOLD_OVF;
                    load    = 1'b1;
                end
            end
            HOLD_OVF: begin
                if (ill_hit) begin
                    next_st = ovf_hit ? HOLD_OVF : HOLD_ILL;
                    load    = 1'b1;
                end
            end
            default: begin
                next_st = HOLD_NONE;
            end
        endcase
    end

    // R5: simultaneous classes always end holding overflow
    a_r5_both_to_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_hit && ovf_hit) |=> (state == HOLD_OVF));

    // R6: acknowledge without an event returns to no held class
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ill_hit && !ovf_hit) |=> (state == HOLD_NONE));

    // R7: no qualified event and no acknowledge keeps the held class
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !ill_hit && !ovf_hit) |=> $stable(state));

endmodule

// File: rtl/exc_cap_reg.sv
module exc_cap_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/exc_addr_capture.sv
module exc_addr_capture
    import exc_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_ILL  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] grp_addr,
    input  logic              grp_valid,
    input  logic [N_ILL-1:0]  ill_evt,
    input  logic              ovf_evt,
    input  logic              exc_ack,
    output logic [ADDR_W-1:0] dbg_rd_data,
    output logic [ADDR_W-1:0] core_rd_data
);

    logic              ill_hit;
    logic              ovf_hit;
    logic              load;
    hold_e             state;
    logic [ADDR_W-1:0] held_addr;

    exc_cap_classify #(.N_ILL(N_ILL)) u_classify (
        .grp_valid (grp_valid),
        .ill_evt   (ill_evt),
        .ovf_evt   (ovf_evt),
        .ill_hit   (ill_hit),
        .ovf_hit   (ovf_hit)
    );

    exc_cap_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ill_hit (ill_hit),
        .ovf_hit (ovf_hit),
        .ack     (exc_ack),
        .state   (state),
        .load    (load)
    );

    exc_cap_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (grp_addr),
        .q     (held_addr)
    );

    assign dbg_rd_data  = held_addr;
    assign core_rd_data = held_addr;

    // R2: with nothing held, a qualified event captures the address
    a_r2_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOLD_NONE && (ill_hit || ovf_hit)) |=> (dbg_rd_data == $past(grp_addr)));

    // R3: repeat of the held illegal class keeps the value
    a_r3_ill_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOLD_ILL && !exc_ack && grp_valid && (|ill_evt) && !ovf_evt) |=> $stable(dbg_rd_data));

    // R3: repeat of the held overflow class keeps the value
    a_r3_ovf_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOLD_OVF && !exc_ack && grp_valid && ovf_evt && !(|ill_evt)) |=> $stable(dbg_rd_data));

    // R4: overflow replaces a held illegal entry
    a_r4_override: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOLD_ILL && grp_valid && ovf_evt) |=> (dbg_rd_data == $past(grp_addr)));

    // R6: an event together with an acknowledge is captured
    a_r6_ack_and_event: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ack && (ill_hit || ovf_hit)) |=> (core_rd_data == $past(grp_addr)));

    // R7: unqualified pulses change nothing
    a_r7_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_valid) |=> $stable(core_rd_data));

    // R8: both read ports agree
    a_r8_ports_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rd_data == core_rd_data));

endmodule

// File: tb/exc_addr_capture_bench.sv
`timescale 1ns/1ps
module exc_addr_capture_bench;

    localparam int ADDR_W = 32;
    localparam int N_ILL  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] grp_addr = '0;
    logic              grp_valid = 1'b0;
    logic [N_ILL-1:0]  ill_evt = '0;
    logic              ovf_evt = 1'b0;
    logic              exc_ack = 1'b0;
    logic [ADDR_W-1:0] dbg_rd_data;
    logic [ADDR_W-1:0] core_rd_data;

    always #4 clk = ~clk;

    exc_addr_capture #(.ADDR_W(ADDR_W), .N_ILL(N_ILL)) u_exc_addr_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .grp_addr     (grp_addr),
        .grp_valid    (grp_valid),
        .ill_evt      (ill_evt),
        .ovf_evt      (ovf_evt),
        .exc_ack      (exc_ack),
        .dbg_rd_data  (dbg_rd_data),
        .core_rd_data (core_rd_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [ADDR_W-1:0] exp_q[$];
    string             tag_q[$];

    // reference model: 0 none, 1 illegal, 2 overflow
    int                m_kind = 0;
    logic [ADDR_W-1:0] m_val  = '0;

    task automatic check_val(input string tag, input logic [ADDR_W-1:0] act,
                             input logic [ADDR_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [N_ILL-1:0] ill, input logic ovf, input logic vld,
                         input logic ack, input logic [ADDR_W-1:0] addr, input string tag);
        int  base;
        logic i_h, o_h;
        @(negedge clk);
        ill_evt = ill; ovf_evt = ovf; grp_valid = vld; exc_ack = ack; grp_addr = addr;
        base = ack ? 0 : m_kind;
        i_h  = vld && (|ill);
        o_h  = vld && ovf;
        if (i_h && o_h) begin
            m_val = addr; m_kind = 2;
        end else if (i_h && base != 1) begin
            m_val = addr; m_kind = 1;
        end else if (o_h && base != 2) begin
            m_val = addr; m_kind = 2;
        end else begin
            m_kind = base;
        end
        exp_q.push_back(m_val);
        tag_q.push_back(tag);
    endtask

    // monitor: one expected item per clock edge, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [ADDR_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_val(t, dbg_rd_data, e);
                check_val({t, "/R8"}, core_rd_data, e);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_val("R1 reset dbg", dbg_rd_data, '0);
        check_val("R1 reset core", core_rd_data, '0);

        drive(3'b001, 0, 1, 0, 32'h0000_1000, "R1/R2 first illegal");
        drive(3'b010, 0, 1, 0, 32'h0000_1010, "R3 illegal sub-reason 1");
        drive(3'b100, 0, 1, 0, 32'h0000_1020, "R3 illegal sub-reason 2");
        drive(3'b000, 1, 1, 0, 32'h0000_2000, "R4 ovf overrides ill");
        drive(3'b000, 1, 1, 0, 32'h0000_2010, "R3 ovf repeat");
        drive(3'b001, 0, 1, 0, 32'h0000_3000, "R4 ill overrides ovf");
        drive(3'b000, 1, 0, 0, 32'h0000_4000, "R7 ovf without valid");
        drive(3'b111, 0, 0, 0, 32'h0000_4010, "R7 ill without valid");
        drive(3'b000, 0, 1, 1, 32'h0000_5000, "R6 ack keeps value");
        drive(3'b010, 0, 1, 0, 32'h0000_6000, "R6 re-armed illegal");
        drive(3'b001, 1, 1, 0, 32'h0000_7000, "R5 both from ill");
        drive(3'b000, 1, 1, 0, 32'h0000_7010, "R5 ovf after both ignored");
        drive(3'b100, 0, 1, 0, 32'h0000_7020, "R5 ill after both captured");
        drive(3'b001, 0, 1, 1, 32'h0000_8000, "R6 ack with same-class event");
        drive(3'b000, 1, 1, 0, 32'h0000_9000, "R4 ovf");
        drive(3'b010, 1, 1, 0, 32'h0000_9010, "R5 both from ovf");
        drive(3'b000, 1, 1, 1, 32'h0000_9020, "R6 ack with ovf");
        drive(3'b000, 0, 0, 0, 32'h0000_0000, "R7 idle");

        lfsr = 32'hACE1_2357;
        for (int k = 0; k < 400; k++) begin
            logic [N_ILL-1:0] ri;
            logic ro, rv, ra;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ri = (lfsr[3:2] == 2'b00) ? lfsr[6:4] : '0;
            ro = (lfsr[9:8] == 2'b00);
            rv = lfsr[10] | lfsr[11];
            ra = (lfsr[15:13] == 3'b000);
            drive(ri, ro, rv, ra, {lfsr[23:0], 8'(k)}, "R2-mix random");
        end
        drive(3'b000, 0, 0, 0, 32'h0, "R7 drain");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule